// File: doc/BRIEF.md
# Addressed Serial Display Frame Receiver

This block receives segment and control bits from a host over a three-wire serial link made of an enable, a clock and a data line. The three lines are synchronised into the system clock domain. While the enable is high, every rising edge of the serial clock shifts one data bit into a frame buffer. A frame is an 8-bit device address followed by 40 payload bits.

When the enable drops, the block checks two things: that exactly 48 bits arrived and that the address matches the device address. The last bit of the frame selects the destination. A 0 writes the lower 28 segments and the two control bits. A 1 writes the upper 26 segments. A 54-segment image therefore needs two frames, and a small display that uses 28 segments or fewer needs only the first.

Each accepted frame raises a one-cycle update strobe. A validity flag shows that both halves have been written at least once since reset. A frame with the wrong address or the wrong length changes nothing.

Top module: `sfr_receiver`

## Requirements
- R1: After reset, `seg_data` is all zeros, `pwr_save`, `blank_all` and `data_valid` are 0, and `upd_strobe` stays low until a frame is accepted.
- R2: A frame is accepted only if its first 8 bits, taken least significant bit first, equal 44h (wire order 0,0,1,0,0,0,1,0). A frame carrying any other address changes no output and gives no strobe.
- R3: A frame is accepted only if exactly 48 serial clock rising edges (8 address bits plus 40 payload bits) occur between the rising and falling edge of `ser_en`. A frame of 47 or 49 bits changes no output and gives no strobe.
- R4: An accepted frame whose last bit is 0 is a lower frame. Its payload bits 0..27 (the bits after the address, in wire order) go to `seg_data[27:0]`, where `seg_data[n-1]` holds segment n and 1 means on. Payload bit 28 goes to `pwr_save` and payload bit 29 goes to `blank_all`. Payload bits 30..38 are ignored, and `seg_data[53:28]` is unchanged.
- R5: An accepted frame whose last bit is 1 is an upper frame. Its payload bits 0..25 go to `seg_data[53:28]`. Payload bits 26..38 are ignored, and `seg_data[27:0]`, `pwr_save` and `blank_all` are unchanged.
- R6: Data is sampled on rising edges of `ser_clk` only while `ser_en` is high. Transfers work the same whether `ser_clk` idles low or high between frames.
- R7: Each accepted frame gives exactly one `upd_strobe` pulse, one system clock wide. The outputs change only in the cycle in which `upd_strobe` is high.
- R8: `data_valid` goes high once both a lower and an upper frame have been accepted since reset, and stays high until the next reset.
- R9: The bit count and frame buffer restart at each rising edge of `ser_en`, so a rejected frame has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable, frame active while high (asynchronous) |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edge (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| seg_data | output | 54 | Stored segment image, bit n-1 is segment n |
| pwr_save | output | 1 | Stored power-saving control bit |
| blank_all | output | 1 | Stored all-segments-off control bit |
| upd_strobe | output | 1 | One-cycle pulse when a frame is committed |
| data_valid | output | 1 | Both halves written since reset |

## Verification
A wrong bit count or a mis-stored address bit shows up at the ports as a frame that is not committed. The strobe is missing and the outputs stay the same a few system cycles after the enable falls. A shift position off by one shows as a segment pattern moved by one place, or as a control bit taken from a segment position. A half-select error shows up as a change in the wrong half of `seg_data`, or as control bits written by an upper frame, in the first frame that uses that half. The sweeps cover many segment patterns, every single-bit address error, off-by-one lengths and both clock idle levels, so each of these faults appears within one frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int ADDR_W    = 8;
  localparam int PAY_W     = 40;
  localparam int SEG_N     = 54;
  localparam int HALF_A    = 28;
  localparam int FRAME_LEN = ADDR_W + PAY_W;
  // bits kept in the buffer: address, lower-half segments, two control bits
  localparam int STORE_LEN = ADDR_W + HALF_A + 2;

  function automatic logic frame_ok(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] dev,
                                    input int unsigned cnt,
                                    input int unsigned len);
    return (addr == dev) && (cnt == len);
  endfunction

  function automatic int unsigned cnt_next(input int unsigned cnt, input int unsigned len);
    // saturate one past the frame length so overlong frames stay detectable
    return (cnt > len) ? cnt : cnt + 1;
  endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int FRAME_LEN = 48,
  parameter int STORE_LEN = 38,
  parameter int CNT_W     = $clog2(FRAME_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_s,
  input  logic                 sck_s,
  input  logic                 dat_s,
  output logic [STORE_LEN-1:0] frame,
  output logic                 last_bit,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic                 en_fall
);
  import sfr_pkg::*;

  logic en_q, sck_q;
  logic en_rise, sck_rise;

  assign en_rise  =  en_s & ~en_q;
  assign en_fall  = ~en_s &  en_q;
  assign sck_rise =  sck_s & ~sck_q & en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      frame    <= '0;
      last_bit <= 1'b0;
    end else if (en_rise) begin
      bit_cnt  <= '0;
      frame    <= '0;
      last_bit <= 1'b0;
    end else if (sck_rise) begin
      if (bit_cnt < CNT_W'(STORE_LEN)) frame[bit_cnt] <= dat_s;
      last_bit <= dat_s;
      bit_cnt  <= CNT_W'(cnt_next(32'(bit_cnt), FRAME_LEN));
    end
  end
endmodule

// File: rtl/sfr_latch.sv
module sfr_latch #(
  parameter int SEG_N  = 54,
  parameter int HALF_A = 28,
  parameter int PLD_W  = HALF_A + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sel_hi,
  input  logic [PLD_W-1:0] pld,
  output logic [SEG_N-1:0] seg_data,
  output logic             pwr_save,
  output logic             blank_all,
  output logic             upd_strobe,
  output logic             data_valid
);
  localparam int HALF_B = SEG_N - HALF_A;

  logic got_lo, got_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_data   <= '0;
      pwr_save   <= 1'b0;
      blank_all  <= 1'b0;
      upd_strobe <= 1'b0;
      got_lo     <= 1'b0;
      got_hi     <= 1'b0;
    end else begin
      upd_strobe <= accept;
      if (accept) begin
        if (!sel_hi) begin
          seg_data[HALF_A-1:0] <= pld[HALF_A-1:0];
          pwr_save             <= pld[HALF_A];
          blank_all            <= pld[HALF_A+1];
          got_lo               <= 1'b1;
        end else begin
          seg_data[SEG_N-1:HALF_A] <= pld[HALF_B-1:0];
          got_hi                   <= 1'b1;
        end
      end
    end
  end

  assign data_valid = got_lo & got_hi;
endmodule

// File: rtl/sfr_receiver.sv
module sfr_receiver #(
  parameter int              SEG_N       = sfr_pkg::SEG_N,
  parameter int              HALF_A      = sfr_pkg::HALF_A,
  parameter int              SYNC_STAGES = 2,
  parameter logic [7:0]      DEV_ADDR    = 8'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [SEG_N-1:0] seg_data,
  output logic             pwr_save,
  output logic             blank_all,
  output logic             upd_strobe,
  output logic             data_valid
);
  import sfr_pkg::*;

  localparam int STORE = ADDR_W + HALF_A + 2;
  localparam int CNT_W = $clog2(FRAME_LEN + 2);

  logic [2:0]       sync_q;
  logic [STORE-1:0] frame_w;
  logic             sel_w;
  logic [CNT_W-1:0] bit_cnt;
  logic             en_fall_w;
  logic             accept_w;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_en, ser_clk, ser_dat}),
    .q(sync_q)
  );

  sfr_shifter #(.FRAME_LEN(FRAME_LEN), .STORE_LEN(STORE), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_s(sync_q[2]), .sck_s(sync_q[1]), .dat_s(sync_q[0]),
    .frame(frame_w), .last_bit(sel_w), .bit_cnt(bit_cnt), .en_fall(en_fall_w)
  );

  assign accept_w = en_fall_w &&
                    frame_ok(frame_w[ADDR_W-1:0], DEV_ADDR, 32'(bit_cnt), FRAME_LEN);

  sfr_latch #(.SEG_N(SEG_N), .HALF_A(HALF_A), .PLD_W(HALF_A + 2)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .accept(accept_w), .sel_hi(sel_w), .pld(frame_w[STORE-1:ADDR_W]),
    .seg_data(seg_data), .pwr_save(pwr_save), .blank_all(blank_all),
    .upd_strobe(upd_strobe), .data_valid(data_valid)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int SEG_N  = 54,
  parameter int HALF_A = 28,
  parameter int CNT_W  = 6,
  parameter int CNT_MAX = 49
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEG_N-1:0] seg_data,
  input logic             pwr_save,
  input logic             blank_all,
  input logic             upd_strobe,
  input logic             data_valid,
  input logic             sel_w,
  input logic             accept_w,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) upd_strobe |=> !upd_strobe); // R7
  AST_STROBE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept_w |=> upd_strobe); // R7
  AST_SEG_CHANGE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (seg_data != $past(seg_data)) |-> upd_strobe); // R7
  AST_LOWER_ONLY_LO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (seg_data[HALF_A-1:0] != $past(seg_data[HALF_A-1:0])) |-> !$past(sel_w)); // R5
  AST_UPPER_ONLY_HI_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (seg_data[SEG_N-1:HALF_A] != $past(seg_data[SEG_N-1:HALF_A])) |-> $past(sel_w)); // R4
  AST_CTRL_ONLY_LO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ({pwr_save, blank_all} != $past({pwr_save, blank_all})) |-> (upd_strobe && !$past(sel_w))); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n) data_valid |=> data_valid); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 32'(bit_cnt) <= CNT_MAX); // R3
endmodule

bind sfr_receiver sfr_checker #(
  .SEG_N(SEG_N), .HALF_A(HALF_A), .CNT_W(CNT_W), .CNT_MAX(sfr_pkg::FRAME_LEN + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_data(seg_data), .pwr_save(pwr_save),
  .blank_all(blank_all), .upd_strobe(upd_strobe), .data_valid(data_valid),
  .sel_w(sel_w), .accept_w(accept_w), .bit_cnt(bit_cnt)
);

// File: tb/tb_sfr_receiver.sv
module tb_sfr_receiver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [53:0] seg_data;
  logic pwr_save, blank_all, upd_strobe, data_valid;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 1'b0;

  logic [53:0] exp_seg = '0;
  logic exp_pwr = 1'b0, exp_blk = 1'b0, exp_got_lo = 1'b0, exp_got_hi = 1'b0;
  int exp_strobes = 0;

  always #2 clk = ~clk;

  sfr_receiver dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .seg_data(seg_data), .pwr_save(pwr_save), .blank_all(blank_all),
    .upd_strobe(upd_strobe), .data_valid(data_valid)
  );

  always @(negedge clk) if (upd_strobe) strobes++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " seg_data"}, 64'(seg_data), 64'(exp_seg));
    check({req, " control"}, {62'd0, pwr_save, blank_all}, {62'd0, exp_pwr, exp_blk});
    check({req, " R8 data_valid"}, 64'(data_valid), 64'(exp_got_lo & exp_got_hi));
    check({req, " R7 strobe count"}, 64'(strobes), 64'(exp_strobes));
  endtask

  task automatic phase();
    repeat (4) @(negedge clk);
  endtask

  // wire order: bit k of the vector is the k-th bit sent
  function automatic logic [63:0] mk_frame(input logic [7:0] addr, input logic [39:0] pay);
    logic [63:0] f = '0;
    for (int k = 0; k < 8; k++) f[k] = addr[k];
    for (int k = 0; k < 40; k++) f[8+k] = pay[k];
    return f;
  endfunction

  function automatic logic [39:0] pay_lo(input logic [27:0] d, input logic bu, input logic sc);
    return {1'b0, 9'd0, sc, bu, d};
  endfunction

  function automatic logic [39:0] pay_hi(input logic [25:0] d, input logic [12:0] junk);
    return {1'b1, junk, d};
  endfunction

  task automatic send(input logic [63:0] bits, input int len, input bit idle_hi);
    ser_clk = idle_hi; ser_dat = 1'b0; phase();
    ser_en = 1'b1; phase();
    for (int k = 0; k < len; k++) begin
      if (idle_hi) begin
        ser_clk = 1'b0; ser_dat = bits[k]; phase();
        ser_clk = 1'b1; phase();
      end else begin
        ser_dat = bits[k]; phase();
        ser_clk = 1'b1; phase();
        ser_clk = 1'b0; phase();
      end
    end
    ser_en = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic model_lo(input logic [27:0] d, input logic bu, input logic sc);
    exp_seg[27:0] = d; exp_pwr = bu; exp_blk = sc; exp_got_lo = 1'b1; exp_strobes++;
  endtask

  task automatic model_hi(input logic [25:0] d);
    exp_seg[53:28] = d; exp_got_hi = 1'b1; exp_strobes++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [27:0] dl;
    logic [25:0] dh;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // first lower frame with clock idling low; valid must stay low
    dl = 28'hA5C3_96F;
    send(mk_frame(8'h44, pay_lo(dl, 1'b1, 1'b0)), 48, 1'b0);
    model_lo(dl, 1'b1, 1'b0);
    check_all("R4 R6 first lower frame idle low");

    // first upper frame with clock idling high; valid rises
    dh = 26'h2B1_D4E7;
    send(mk_frame(8'h44, pay_hi(dh, 13'h0)), 48, 1'b1);
    model_hi(dh);
    check_all("R5 R6 first upper frame idle high");

    // pattern sweep, alternating halves and idle levels
    for (int i = 0; i < 12; i++) begin
      dl = 28'((i + 1) * 32'h9E37_79B1) ^ 28'(i << 7);
      dh = 26'((i + 3) * 32'h85EB_CA6B);
      send(mk_frame(8'h44, pay_lo(dl, i[0], i[1])), 48, i[1]);
      model_lo(dl, i[0], i[1]);
      check_all("R4 sweep lower");
      send(mk_frame(8'h44, pay_hi(dh, 13'(i * 613))), 48, !i[1]);
      model_hi(dh);
      check_all("R5 sweep upper, ignored bits");
    end

    // ignored lower-frame bits 30..38 set
    dl = 28'h0F0_F0F1;
    send(mk_frame(8'h44, {1'b0, 9'h1FF, 1'b1, 1'b1, dl}), 48, 1'b0);
    model_lo(dl, 1'b1, 1'b1);
    check_all("R4 lower-frame unused bits ignored");

    // every single-bit address error is rejected
    for (int b = 0; b < 8; b++) begin
      send(mk_frame(8'h44 ^ (8'h1 << b), pay_lo(28'h1234567, 1'b0, 1'b0)), 48, b[0]);
      check_all("R2 address mismatch");
    end

    // wrong lengths rejected
    send(mk_frame(8'h44, pay_lo(28'hFFFFFFF, 1'b0, 1'b0)), 47, 1'b0);
    check_all("R3 short frame 47 bits");
    send(mk_frame(8'h44, pay_hi(26'h3FFFFFF, 13'h0)) | (64'h1 << 48), 49, 1'b1);
    check_all("R3 long frame 49 bits");

    // restart after a rejected frame
    dh = 26'h155_5555;
    send(mk_frame(8'h44, pay_hi(dh, 13'h0)), 48, 1'b0);
    model_hi(dh);
    check_all("R9 frame after rejected frame");

    // clock activity with enable low is not sampled
    for (int k = 0; k < 60; k++) begin
      ser_dat = k[0]; ser_clk = 1'b1; phase(); ser_clk = 1'b0; phase();
    end
    repeat (12) @(negedge clk);
    check_all("R6 clock with enable low ignored");

    // all control combinations
    for (int c = 0; c < 4; c++) begin
      dl = 28'(c * 32'h0111_1111);
      send(mk_frame(8'h44, pay_lo(dl, c[0], c[1])), 48, c[0]);
      model_lo(dl, c[0], c[1]);
      check_all("R4 control bits");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule